// File: doc/BRIEF.md
# Bridge Configuration Access Unit

This block accepts one configuration request at a time from a host: a target bus number, device number, function number, register offset, access length of 1, 2 or 4 bytes, a direction and, for writes, the data. It decides whether the target can be reached and builds the backend bus address. A target on the local bus (bus 0) gets a local-type address in which the device is selected by a one-hot select line. A target behind further bridges gets a forwarded-type address. On every valid access the block also rewrites a window register, which holds the high part of the selection that does not fit in the address.

Reads fetch the aligned 32-bit word and return the addressed lanes, shifted down to bit 0. A 1- or 2-byte write is done as a read of the word, a merge of the new lanes, and a write of the word back. A 4-byte write goes straight out. When the backend reports a bus error, the response data is all ones. A request the block cannot address completes at once with an error and makes no backend cycle.

Top module: `cfg_access_unit`

## Requirements
- R1: A request whose length is not 1, 2 or 4 is acknowledged with `rsp_err`=1 and `rsp_rdata`=0, and no backend cycle is made.
- R2: On bus 0, a device number of 16 or more is acknowledged with an error and makes no backend cycle.
- R3: While `cardbus_mode` is 1, any device number other than 0 is rejected with an error and no backend cycle, on every bus. Device 0 is still served.
- R4: A bus 0 access uses the one-hot value S = 1<<(dev+16). The address is 0x0C000000 | (S & 0x03FFFFFF) | func<<8 | (offset & ~3). The window register becomes 0x00000002 | (S & 0xFC000000).
- R5: On a bus other than 0, the address is 0x0C000000 | bus<<16 | dev<<11 | func<<8 | (offset & ~3), and the window register becomes 0x00000003.
- R6: A read returns (word >> 8*(offset&3)), masked to its low 1, 2 or 4 bytes, with `rsp_err`=0.
- R7: A 1- or 2-byte write makes exactly two backend cycles on the same address: a read, then a write of that word with the 0xFF or 0xFFFF lane at 8*(offset&3) replaced by the new data. Bits shifted past bit 31 are dropped.
- R8: A 4-byte write makes exactly one backend write, carrying the request data unchanged.
- R9: A backend bus error ends the request with `rsp_err`=1 and `rsp_rdata`=0xFFFFFFFF. If the error comes on the read of a read-modify-write, no write follows.
- R10: `ack` is a one-cycle pulse. `busy` is high from acceptance until the acknowledge of a request that reaches the backend, and is low while `ack` is high. A request is not accepted in the cycle in which `ack` is high.
- R11: `be_valid`, `be_addr`, `be_write` and `be_wdata` stay stable until `be_done`, whatever the backend latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cardbus_mode | input | 1 | Only device 0 is reachable when this is high |
| req | input | 1 | Request, held until `ack` |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_off | input | 8 | Register byte offset |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| ack | output | 1 | Completion pulse |
| busy | output | 1 | A backend transaction is in progress |
| rsp_err | output | 1 | Error flag, valid with `ack` |
| rsp_rdata | output | 32 | Response data, valid with `ack` |
| win_reg | output | 32 | Window register |
| be_valid | output | 1 | Backend cycle request |
| be_write | output | 1 | Backend cycle is a write |
| be_addr | output | 32 | Backend word address |
| be_wdata | output | 32 | Backend write data |
| be_done | input | 1 | Backend completion pulse |
| be_rdata | input | 32 | Backend read data, valid with `be_done` |
| be_err | input | 1 | Backend bus error, valid with `be_done` |

## Verification
A wrong latched lane or length shows up on the same acknowledge, as wrong read data or as a wrong word in the backend memory, which the next read exposes. A wrong state-machine state shows up as an extra or a missing backend cycle, or as a `busy` or `ack` level that the bench compares on every clock against its own model. Errors in address or window decoding show up at the first backend cycle of the request. Backends with short and long latencies, and with injected errors, make sure a wrong hold or a missing abort is seen within one transaction.

// File: rtl/cfg_access_unit.sv
module cfg_access_unit #(
  parameter int          BUS_W    = 8,
  parameter int          DEV_W    = 5,
  parameter int          FN_W     = 3,
  parameter int          OFF_W    = 8,
  parameter int          SLOTS    = 16,
  parameter logic [31:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [31:0] WIN_T0   = 32'h0000_0002,
  parameter logic [31:0] WIN_T1   = 32'h0000_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cardbus_mode,
  input  logic             req,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [FN_W-1:0]  req_func,
  input  logic [OFF_W-1:0] req_off,
  input  logic [2:0]       req_len,
  input  logic [31:0]      req_wdata,
  output logic             ack,
  output logic             busy,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic [31:0]      win_reg,
  output logic             be_valid,
  output logic             be_write,
  output logic [31:0]      be_addr,
  output logic [31:0]      be_wdata,
  input  logic             be_done,
  input  logic [31:0]      be_rdata,
  input  logic             be_err
);
  localparam int SEL_W = DEV_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic        wr_q;
  logic [2:0]  len_q;
  logic [1:0]  lane_q;
  logic [31:0] wdata_q;

  logic             len_ok, dev_bad, take, full_wr;
  logic [SEL_W-1:0] sel_pos;
  logic [31:0]      sel_bit, off_w, t0_addr, t1_addr, t0_win;
  logic [31:0]      lmask, rd_val, merged;
  logic [4:0]       sh;

  assign len_ok  = (req_len == 3'd1) || (req_len == 3'd2) || (req_len == 3'd4);
  assign dev_bad = (cardbus_mode && req_dev != '0) ||
                   (req_bus == '0 && int'(req_dev) >= SLOTS);
  assign take    = (st == S_IDLE) && req && !ack;
  assign full_wr = req_write && (req_len == 3'd4);

  assign sel_pos = SEL_W'(req_dev) + SEL_W'(16);
  assign sel_bit = 32'd1 << sel_pos;
  assign off_w   = 32'(req_off) & ~32'd3;
  assign t0_addr = CFG_BASE | (sel_bit & ~WIN_MASK) | (32'(req_func) << 8) | off_w;
  assign t0_win  = WIN_T0 | (sel_bit & WIN_MASK);
  assign t1_addr = CFG_BASE | (32'(req_bus) << 16) | (32'(req_dev) << 11) |
                   (32'(req_func) << 8) | off_w;

  assign lmask  = (len_q == 3'd1) ? 32'h0000_00FF :
                  (len_q == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign sh     = {lane_q, 3'b000};
  assign rd_val = (be_rdata >> sh) & lmask;
  assign merged = (be_rdata & ~(lmask << sh)) | ((wdata_q & lmask) << sh);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ack       <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      win_reg   <= '0;
      be_valid  <= 1'b0;
      be_write  <= 1'b0;
      be_addr   <= '0;
      be_wdata  <= '0;
      wr_q      <= 1'b0;
      len_q     <= '0;
      lane_q    <= '0;
      wdata_q   <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (!len_ok || dev_bad) begin
            ack       <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end else begin
            win_reg  <= (req_bus == '0) ? t0_win : WIN_T1;
            be_addr  <= (req_bus == '0) ? t0_addr : t1_addr;
            be_valid <= 1'b1;
            be_write <= full_wr;
            be_wdata <= req_wdata;
            wr_q     <= req_write;
            len_q    <= req_len;
            lane_q   <= req_off[1:0];
            wdata_q  <= req_wdata;
            st       <= full_wr ? S_WR : S_RD;
          end
        end
        S_RD: if (be_done) begin
          if (be_err) begin
            be_valid  <= 1'b0;
            ack       <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= 32'hFFFF_FFFF;
            st        <= S_IDLE;
          end else if (wr_q) begin
            be_write <= 1'b1;
            be_wdata <= merged;
            st       <= S_WR;
          end else begin
            be_valid  <= 1'b0;
            ack       <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= rd_val;
            st        <= S_IDLE;
          end
        end
        S_WR: if (be_done) begin
          be_valid  <= 1'b0;
          be_write  <= 1'b0;
          ack       <= 1'b1;
          rsp_err   <= be_err;
          rsp_rdata <= be_err ? 32'hFFFF_FFFF : 32'h0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ack);
  p_reject_fast_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !len_ok) |=> (ack && rsp_err && !be_valid));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (be_valid && !be_done) |=> (be_valid && $stable(be_addr) &&
                                $stable(be_write) && $stable(be_wdata)));
  p_err_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (be_valid && be_done && be_err) |=>
      (ack && rsp_err && rsp_rdata == 32'hFFFF_FFFF && !be_valid));
  p_rmw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && be_done && !be_err && wr_q) |=>
      (be_valid && be_write && $stable(be_addr)));
endmodule

// File: tb/cfg_access_unit_tb.sv
module cfg_access_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cardbus_mode = 1'b0;
  logic        req = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_off = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        ack, busy, rsp_err;
  logic [31:0] rsp_rdata, win_reg;
  logic        be_valid, be_write;
  logic [31:0] be_addr, be_wdata;
  logic        be_done = 1'b0;
  logic [31:0] be_rdata = '0;
  logic        be_err = 1'b0;

  cfg_access_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cardbus_mode(cardbus_mode),
    .req(req), .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev),
    .req_func(req_func), .req_off(req_off), .req_len(req_len),
    .req_wdata(req_wdata), .ack(ack), .busy(busy), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .win_reg(win_reg), .be_valid(be_valid),
    .be_write(be_write), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_done(be_done), .be_rdata(be_rdata), .be_err(be_err)
  );

  int errors = 0, checks = 0;
  int lat = 2;
  bit inj_err = 1'b0;
  int n_acc = 0, n_wr = 0, cnt = 0;
  logic [31:0] last_addr = '0, last_wdata = '0;
  logic [31:0] mem [logic [31:0]];
  bit in_flight = 1'b0;
  bit finished = 1'b0;

  function automatic logic [31:0] memrd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A5A_1234;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // backend model
  always @(negedge clk) begin
    if (!rst_n) begin
      be_done = 1'b0; be_err = 1'b0; cnt = 0;
    end else if (be_done) begin
      be_done = 1'b0; be_err = 1'b0; cnt = 0;
    end else if (be_valid) begin
      cnt++;
      if (cnt >= lat) begin
        n_acc++;
        last_addr = be_addr;
        if (inj_err) be_err = 1'b1;
        else if (be_write) begin
          mem[be_addr] = be_wdata; n_wr++; last_wdata = be_wdata;
        end else be_rdata = memrd(be_addr);
        be_done = 1'b1;
      end
    end
  end

  // every-clock comparison: idle unit must not be busy or driving the backend
  always @(negedge clk) begin
    if (rst_n && !in_flight && !finished) begin
      chk(!busy && !be_valid && !ack, "R10 idle quiet", {busy, be_valid, ack}, 0);
    end
  end

  function automatic logic [31:0] e_addr(input int bus, input int dev,
                                         input int fn, input int off);
    logic [31:0] a;
    a = 32'h0C00_0000 + fn * 256 + (off / 4) * 4;
    if (bus == 0) begin
      if (dev < 10) a = a + (32'd1 << (dev + 16));
    end else a = a + bus * 65536 + dev * 2048;
    return a;
  endfunction

  function automatic logic [31:0] e_win(input int bus, input int dev);
    if (bus != 0) return 32'h3;
    return (dev >= 10) ? (32'h2 + (32'd1 << (dev + 16))) : 32'h2;
  endfunction

  function automatic logic [31:0] lenmask(input int len);
    return (len == 1) ? 32'hFF : (len == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // run one request; returns the response
  task automatic run(input bit wr, input int bus, input int dev, input int fn,
                     input int off, input int len, input logic [31:0] wd,
                     output bit err, output logic [31:0] rd, output int acc,
                     output int wrs);
    int a0, w0, n;
    a0 = n_acc; w0 = n_wr; n = 0;
    @(negedge clk);
    in_flight = 1'b1;
    req_write = wr; req_bus = 8'(bus); req_dev = 5'(dev); req_func = 3'(fn);
    req_off = 8'(off); req_len = 3'(len); req_wdata = wd; req = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (ack) break;
      chk(busy, "R10 busy while pending", {31'b0, busy}, 1);
      if (n > 200) begin
        chk(1'b0, "R10 request timeout", 0, 1);
        break;
      end
    end
    err = rsp_err; rd = rsp_rdata;
    chk(!busy, "R10 busy low at ack", {31'b0, busy}, 0);
    req = 1'b0;
    acc = n_acc - a0; wrs = n_wr - w0;
    @(negedge clk);
    chk(!ack, "R10 ack single pulse", {31'b0, ack}, 0);
    in_flight = 1'b0;
  endtask

  task automatic do_read(input int bus, input int dev, input int fn, input int off,
                         input int len, input string tag);
    bit e; logic [31:0] r, a, exp; int acc, wrs;
    a = e_addr(bus, dev, fn, off);
    exp = (memrd(a) >> (8 * (off % 4))) & lenmask(len);
    run(1'b0, bus, dev, fn, off, len, 32'h0, e, r, acc, wrs);
    chk(!e && r == exp, {tag, " read data"}, r, exp);
    chk(acc == 1 && last_addr == a, {tag, " address"}, last_addr, a);
    chk(win_reg == e_win(bus, dev), {tag, " window"}, win_reg, e_win(bus, dev));
  endtask

  task automatic do_write(input int bus, input int dev, input int fn, input int off,
                          input int len, input logic [31:0] wd, input string tag);
    bit e; logic [31:0] r, a, old, mk, exp; int acc, wrs, sh;
    a = e_addr(bus, dev, fn, off);
    old = memrd(a);
    sh = 8 * (off % 4);
    if (len == 4) exp = wd;
    else begin
      mk = lenmask(len) << sh;
      exp = (old & ~mk) | ((wd & lenmask(len)) << sh);
    end
    run(1'b1, bus, dev, fn, off, len, wd, e, r, acc, wrs);
    chk(!e, {tag, " no error"}, {31'b0, e}, 0);
    chk(acc == ((len == 4) ? 1 : 2) && wrs == 1, {tag, " backend cycles"}, acc,
        (len == 4) ? 1 : 2);
    chk(last_addr == a && memrd(a) == exp, {tag, " stored word"}, memrd(a), exp);
    chk(win_reg == e_win(bus, dev), {tag, " window"}, win_reg, e_win(bus, dev));
  endtask

  task automatic do_reject(input bit wr, input int bus, input int dev, input int off,
                           input int len, input string tag);
    bit e; logic [31:0] r; int acc, wrs;
    run(wr, bus, dev, 0, off, len, 32'hDEAD_BEEF, e, r, acc, wrs);
    chk(e && r == 0, {tag, " rejected"}, r, 0);
    chk(acc == 0, {tag, " no backend cycle"}, acc, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "R10 watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit e; logic [31:0] r; int acc, wrs;
    repeat (3) @(negedge clk);
    chk(!ack && !busy && !be_valid && win_reg == 0, "R10 reset state",
        {ack, busy, be_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_read(0, 0, 0, 8'h00, 4, "R4 R6 bus0 dev0");
    do_read(0, 12, 3, 8'h0E, 2, "R4 R6 bus0 dev12");
    do_read(0, 15, 7, 8'hFF, 1, "R4 R6 bus0 dev15");
    do_read(5, 7, 2, 8'h41, 1, "R5 R6 bus5");
    do_read(1, 20, 1, 8'h07, 4, "R5 R6 bus1 dev20");

    do_write(0, 3, 0, 8'h13, 1, 32'hFFFF_FF3C, "R7 byte write");
    do_read(0, 3, 0, 8'h13, 1, "R7 byte readback");
    do_write(2, 4, 5, 8'h22, 2, 32'h0000_BEEF, "R7 half write");
    do_write(0, 9, 1, 8'h23, 2, 32'h0000_A1B2, "R7 half write top lane");
    do_write(0, 11, 0, 8'h31, 4, 32'h1234_5678, "R8 word write");
    do_read(0, 11, 0, 8'h30, 4, "R8 word readback");

    do_reject(1'b0, 0, 0, 0, 3, "R1 len3");
    do_reject(1'b1, 0, 0, 0, 0, "R1 len0");
    do_reject(1'b0, 0, 16, 0, 4, "R2 dev16");
    do_reject(1'b0, 0, 31, 0, 4, "R2 dev31");

    cardbus_mode = 1'b1;
    do_reject(1'b0, 0, 1, 0, 4, "R3 cardbus dev1");
    do_reject(1'b1, 2, 1, 0, 4, "R3 cardbus bus2 dev1");
    do_read(0, 0, 0, 8'h10, 4, "R3 cardbus dev0");
    cardbus_mode = 1'b0;

    inj_err = 1'b1;
    run(1'b0, 0, 1, 0, 8'h04, 4, 32'h0, e, r, acc, wrs);
    chk(e && r == 32'hFFFF_FFFF, "R9 read bus error", r, 32'hFFFF_FFFF);
    run(1'b1, 0, 1, 0, 8'h05, 1, 32'h77, e, r, acc, wrs);
    chk(e && r == 32'hFFFF_FFFF, "R9 rmw bus error data", r, 32'hFFFF_FFFF);
    chk(acc == 1 && wrs == 0, "R9 rmw aborted", acc, 1);
    run(1'b1, 0, 1, 0, 8'h08, 4, 32'h55, e, r, acc, wrs);
    chk(e && r == 32'hFFFF_FFFF, "R9 word write bus error", r, 32'hFFFF_FFFF);
    inj_err = 1'b0;

    lat = 1;
    do_write(0, 6, 2, 8'h1A, 2, 32'h0000_C0DE, "R11 fast backend");
    lat = 7;
    do_write(3, 2, 0, 8'h2D, 1, 32'h0000_009E, "R11 slow backend");
    do_read(3, 2, 0, 8'h2C, 4, "R11 slow readback");
    lat = 2;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule